// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block gathers the five interrupt causes of a serial port, applies a four-bit enable mask and reports exactly one cause at a time as a four-bit identification code. The causes are a receive line error, a receive timeout, receive data at or above the trigger level, an empty transmit holding register, and a change on a modem input. When more than one cause is pending, only the most urgent one shows. A less urgent cause shows once every cause above it has been cleared.

Two of the causes are levels supplied by the receive path: the timeout condition and the trigger-level condition. The other three are latched from one-cycle event pulses. Each cause has its own clearing access. The identification byte also carries two FIFO-enabled flags in its top bits. The single interrupt output is qualified by an output-enable bit taken from the modem control register. Timeout counting and modem input synchronisation happen upstream, and this block sees only their results.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00, the interrupt output is low, and identification bits 3:0 read 0001.
- R2: The identification codes in bits 3:0 are: line error 0110, receive timeout 1100, receive data ready 0100, transmit empty 0010, modem change 0000. Bit 0 is an active-low pending flag, so 0001 means nothing is pending.
- R3: The urgency order from most to least is: line error, timeout, data ready, transmit empty, modem change. Only the most urgent enabled pending cause is reported. The next one appears in the cycle after the higher one clears.
- R4: A line error pulse latches the line cause. The cause stays latched until a line status register read strobe.
- R5: The timeout cause and the data-ready cause follow their input levels, with a one-cycle register delay. A receive holding register read strobe drops both for the following cycle.
- R6: A transmit-empty event pulse latches the transmit cause. It is cleared by a holding register write strobe. It is also cleared by an identification read strobe, but only while transmit empty is the code being reported. An identification read at any other time leaves it latched.
- R7: A modem change pulse latches the modem cause. The cause stays latched until a modem status register read strobe.
- R8: An enable write stores bits 3:0. Bit 0 enables both the timeout cause and the data-ready cause. Bit 1 enables transmit empty, bit 2 enables line error, and bit 3 enables modem change. Bits 7:4 always read 0. A disabled cause is not reported, but it stays latched and is reported once it is enabled.
- R9: Identification bits 7:6 both equal the FIFO-enable input, and bits 5:4 read 0.
- R10: The interrupt output is high only when the output-enable input is high and a cause is being reported.
- R11: When a latching event and its clear strobe arrive in the same cycle, the event wins and the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| fifo_en | input | 1 | FIFOs enabled, mirrored into identification bits 7:6 |
| out_en | input | 1 | Interrupt output enable from modem control |
| line_err | input | 1 | Pulse: receive line error detected |
| rx_tmo | input | 1 | Level: receive timeout condition |
| rx_at_trig | input | 1 | Level: receive data at or above trigger level |
| tx_evt | input | 1 | Pulse: transmit holding register became empty |
| modem_delta | input | 1 | Pulse: a modem input changed |
| lsr_rd | input | 1 | Strobe: line status register read |
| msr_rd | input | 1 | Strobe: modem status register read |
| iir_rd | input | 1 | Strobe: identification register read |
| thr_wr | input | 1 | Strobe: transmit holding register write |
| rhr_rd | input | 1 | Strobe: receive holding register read |
| ien_rdata | output | 8 | Enable register readback |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default register width of 8. At that width every one of the six codes and both fixed fields of the identification byte can be observed at the ports. The directed scenarios stack all five causes, then peel them off one clear at a time, so each step of the urgency order is seen. They also cover the conditional transmit clear, the enable mask hiding a latched cause, the one-cycle drop on a holding read, and the event-versus-clear collision.

// File: rtl/uart_irq_pkg.sv
// Shared constants and code helpers for the interrupt identification unit.
// Source index equals urgency rank minus one (0 is most urgent).
package uart_irq_pkg;

    localparam int NSRC  = 5;
    localparam int ID_W  = 4;
    localparam int EN_W  = 4;

    localparam int S_LINE  = 0;
    localparam int S_TMO   = 1;
    localparam int S_RXRDY = 2;
    localparam int S_TXE   = 3;
    localparam int S_MODEM = 4;

    localparam logic [ID_W-1:0] CODE_NONE = 4'b0001;

    // Identification code of a source index.
    function automatic logic [ID_W-1:0] code_of(input int idx);
        case (idx)
            S_LINE:  code_of = 4'b0110;
            S_TMO:   code_of = 4'b1100;
            S_RXRDY: code_of = 4'b0100;
            S_TXE:   code_of = 4'b0010;
            default: code_of = 4'b0000;
        endcase
    endfunction

    // Enable register bit that gates a source index.
    function automatic int en_bit_of(input int idx);
        case (idx)
            S_LINE:  en_bit_of = 2;
            S_TMO:   en_bit_of = 0;
            S_RXRDY: en_bit_of = 0;
            S_TXE:   en_bit_of = 1;
            default: en_bit_of = 3;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_srcs.sv
// Pending-flag bank. Holds one flag per interrupt source.
// Assumes event inputs are single-cycle pulses and clear inputs are
// single-cycle strobes; a set and clear in the same cycle keeps the flag.
module uart_irq_srcs
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_err,
    input  logic            rx_tmo,
    input  logic            rx_at_trig,
    input  logic            tx_evt,
    input  logic            modem_delta,
    input  logic            lsr_rd,
    input  logic            msr_rd,
    input  logic            iir_rd,
    input  logic            thr_wr,
    input  logic            rhr_rd,
    input  logic            tx_reported,
    output logic [NSRC-1:0] pend
);

    // Latched causes: event sets, own strobe clears, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend[S_LINE]  <= 1'b0;
            pend[S_TXE]   <= 1'b0;
            pend[S_MODEM] <= 1'b0;
        end else begin
            pend[S_LINE]  <= line_err    | (pend[S_LINE]  & ~lsr_rd);
            pend[S_TXE]   <= tx_evt      | (pend[S_TXE]   & ~thr_wr
                                                           & ~(iir_rd & tx_reported));
            pend[S_MODEM] <= modem_delta | (pend[S_MODEM] & ~msr_rd);
        end
    end

    // Level causes: follow receive-path levels, dropped for a cycle on a holding read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend[S_TMO]   <= 1'b0;
            pend[S_RXRDY] <= 1'b0;
        end else begin
            pend[S_TMO]   <= rx_tmo     & ~rhr_rd;
            pend[S_RXRDY] <= rx_at_trig & ~rhr_rd;
        end
    end

endmodule

// File: rtl/uart_irq_ien.sv
// Enable register and per-source mask. Stores the low EN_W bits of a write;
// upper readback bits are zero. Assumes REG_W >= EN_W.
module uart_irq_ien
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [REG_W-1:0] ien_wdata,
    input  logic [NSRC-1:0]  pend,
    output logic [REG_W-1:0] ien_rdata,
    output logic [NSRC-1:0]  active
);

    localparam int PAD_W = REG_W - EN_W;

    logic [EN_W-1:0] en_q;

    // Enable register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (ien_wr)
            en_q <= ien_wdata[EN_W-1:0];
    end

    assign ien_rdata = {{PAD_W{1'b0}}, en_q};

    // Mask each pending flag by the enable bit that governs it.
    for (genvar i = 0; i < NSRC; i++) begin : g_mask
        localparam int EB = en_bit_of(i);
        assign active[i] = pend[i] & en_q[EB];
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-order selector. Picks the lowest-index active source and returns
// its code, a one-hot select vector and an any-pending flag.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] active,
    output logic [NSRC-1:0] sel,
    output logic [ID_W-1:0] code,
    output logic            any
);

    logic [NSRC:0]          blocked;
    logic [ID_W-1:0]        term [NSRC];
    logic [ID_W-1:0]        code_or;

    assign blocked[0] = 1'b0;

    // Blocking chain: a source is selected when nothing above it is active.
    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign blocked[i+1] = blocked[i] | active[i];
        assign sel[i]       = active[i] & ~blocked[i];
        assign term[i]      = sel[i] ? code_of(i) : '0;
    end

    // Merge the one-hot selected code.
    always_comb begin
        code_or = '0;
        for (int i = 0; i < NSRC; i++)
            code_or = code_or | term[i];
    end

    assign any  = blocked[NSRC];
    assign code = any ? code_or : CODE_NONE;

endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identification unit. Latches causes, masks them,
// reports the most urgent one and drives the gated interrupt output.
// Assumes REG_W >= 8 so the identification byte holds all fixed fields.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [REG_W-1:0] ien_wdata,
    input  logic             fifo_en,
    input  logic             out_en,
    input  logic             line_err,
    input  logic             rx_tmo,
    input  logic             rx_at_trig,
    input  logic             tx_evt,
    input  logic             modem_delta,
    input  logic             lsr_rd,
    input  logic             msr_rd,
    input  logic             iir_rd,
    input  logic             thr_wr,
    input  logic             rhr_rd,
    output logic [REG_W-1:0] ien_rdata,
    output logic [REG_W-1:0] iir,
    output logic             irq
);

    localparam int MID_W = REG_W - ID_W - 2;

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] active;
    logic [NSRC-1:0] sel;
    logic [ID_W-1:0] code;
    logic            any;

    uart_irq_srcs u_srcs (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_err    (line_err),
        .rx_tmo      (rx_tmo),
        .rx_at_trig  (rx_at_trig),
        .tx_evt      (tx_evt),
        .modem_delta (modem_delta),
        .lsr_rd      (lsr_rd),
        .msr_rd      (msr_rd),
        .iir_rd      (iir_rd),
        .thr_wr      (thr_wr),
        .rhr_rd      (rhr_rd),
        .tx_reported (sel[S_TXE]),
        .pend        (pend)
    );

    uart_irq_ien #(.REG_W(REG_W)) u_ien (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .pend      (pend),
        .ien_rdata (ien_rdata),
        .active    (active)
    );

    uart_irq_prio u_prio (
        .active (active),
        .sel    (sel),
        .code   (code),
        .any    (any)
    );

    // Identification byte and gated interrupt output.
    assign iir = {{2{fifo_en}}, {MID_W{1'b0}}, code};
    assign irq = out_en & any;

endmodule

// File: rtl/uart_irq_ident_chk.sv
// Property checker for uart_irq_ident, attached by bind below.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ien_wr,
    input logic       fifo_en,
    input logic       out_en,
    input logic       line_err,
    input logic       tx_evt,
    input logic       modem_delta,
    input logic       msr_rd,
    input logic       thr_wr,
    input logic [7:0] ien_rdata,
    input logic [7:0] iir,
    input logic       irq
);

    AST_IEN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ien_rdata[7:4] == 4'b0000);                                              // R8
    AST_IIR_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (iir[5:4] == 2'b00) && (iir[7:6] == {2{fifo_en}}));                      // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (out_en && !iir[0]));                                            // R10
    AST_LINE_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && ien_rdata[2] && !ien_wr) |=> (iir[3:0] == 4'b0110));        // R3
    AST_MODEM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !modem_delta && iir[3:0] == 4'b0000) |=> (iir[3:0] != 4'b0000)); // R7
    AST_THR_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !tx_evt) |=> (iir[3:0] != 4'b0010));                          // R6
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_delta && ien_rdata[3] && !ien_wr) |=> !iir[0]);                   // R11

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ien_wr      (ien_wr),
    .fifo_en     (fifo_en),
    .out_en      (out_en),
    .line_err    (line_err),
    .tx_evt      (tx_evt),
    .modem_delta (modem_delta),
    .msr_rd      (msr_rd),
    .thr_wr      (thr_wr),
    .ien_rdata   (ien_rdata[7:0]),
    .iir         (iir[7:0]),
    .irq         (irq)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ien_wr = 1'b0;
    logic [7:0] ien_wdata = '0;
    logic       fifo_en = 1'b0;
    logic       out_en = 1'b0;
    logic       line_err = 1'b0;
    logic       rx_tmo = 1'b0;
    logic       rx_at_trig = 1'b0;
    logic       tx_evt = 1'b0;
    logic       modem_delta = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       msr_rd = 1'b0;
    logic       iir_rd = 1'b0;
    logic       thr_wr = 1'b0;
    logic       rhr_rd = 1'b0;
    logic [7:0] ien_rdata;
    logic [7:0] iir;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .fifo_en(fifo_en), .out_en(out_en), .line_err(line_err),
        .rx_tmo(rx_tmo), .rx_at_trig(rx_at_trig), .tx_evt(tx_evt),
        .modem_delta(modem_delta), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .rhr_rd(rhr_rd),
        .ien_rdata(ien_rdata), .iir(iir), .irq(irq)
    );

    // One clock: pass the rising edge, return at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] ex(input logic [3:0] code);
        return {{2{fifo_en}}, 2'b00, code};
    endfunction

    task automatic wr_ien(input logic [7:0] d);
        ien_wr = 1'b1; ien_wdata = d; step(); ien_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 iir", iir, 8'h01);
        chk("R1 ien", ien_rdata, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_enable_reg();
        wr_ien(8'hFF);
        chk("R8 upper zero", ien_rdata, 8'h0F);
        fifo_en = 1'b1; #1;
        chk("R9 fifo flags", iir, 8'hC1);
        fifo_en = 1'b0; #1;
        chk("R9 fifo off", iir, 8'h01);
        fifo_en = 1'b1;
        out_en = 1'b1;
    endtask

    task automatic t_stack();
        modem_delta = 1'b1; step(); modem_delta = 1'b0;
        chk("R7 modem code", iir, ex(4'b0000));
        chk("R10 irq on", {7'b0, irq}, 8'h01);
        tx_evt = 1'b1; step(); tx_evt = 1'b0;
        chk("R2 tx over modem", iir, ex(4'b0010));
        rx_at_trig = 1'b1; step();
        chk("R5 rx ready", iir, ex(4'b0100));
        rx_tmo = 1'b1; step();
        chk("R2 timeout", iir, ex(4'b1100));
        line_err = 1'b1; step(); line_err = 1'b0;
        chk("R4 line error", iir, ex(4'b0110));
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk("R3 after lsr read", iir, ex(4'b1100));
        rx_tmo = 1'b0; step();
        chk("R3 after timeout drops", iir, ex(4'b0100));
        rx_at_trig = 1'b0; step();
        chk("R3 after rx drops", iir, ex(4'b0010));
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R6 iir read clears tx", iir, ex(4'b0000));
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        chk("R7 msr read clears", iir, ex(4'b0001));
        chk("R10 irq off", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_rhr_read();
        rx_at_trig = 1'b1; step();
        chk("R5 level seen", iir, ex(4'b0100));
        rhr_rd = 1'b1; step(); rhr_rd = 1'b0;
        chk("R5 dropped on read", iir, ex(4'b0001));
        step();
        chk("R5 back while level", iir, ex(4'b0100));
        rx_at_trig = 1'b0; step();
        chk("R5 level gone", iir, ex(4'b0001));
    endtask

    task automatic t_tx_clears();
        line_err = 1'b1; tx_evt = 1'b1; step(); line_err = 1'b0; tx_evt = 1'b0;
        chk("R3 line over tx", iir, ex(4'b0110));
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk("R6 tx kept after other read", iir, ex(4'b0010));
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
        chk("R6 thr write clears", iir, ex(4'b0001));
    endtask

    task automatic t_mask();
        wr_ien(8'h0B);
        line_err = 1'b1; step(); line_err = 1'b0;
        chk("R8 masked line", iir, ex(4'b0001));
        chk("R8 masked irq", {7'b0, irq}, 8'h00);
        wr_ien(8'h0F);
        chk("R8 latched shows", iir, ex(4'b0110));
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        wr_ien(8'h0E);
        rx_tmo = 1'b1; step();
        chk("R8 bit0 off hides timeout", iir, ex(4'b0001));
        wr_ien(8'h01);
        chk("R8 bit0 on shows timeout", iir, ex(4'b1100));
        rx_tmo = 1'b0; step();
        chk("R5 timeout released", iir, ex(4'b0001));
        wr_ien(8'h0F);
    endtask

    task automatic t_out_en();
        out_en = 1'b0;
        modem_delta = 1'b1; step(); modem_delta = 1'b0;
        chk("R10 pending", iir, ex(4'b0000));
        chk("R10 gated off", {7'b0, irq}, 8'h00);
        out_en = 1'b1; #1;
        chk("R10 gated on", {7'b0, irq}, 8'h01);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
    endtask

    task automatic t_collide();
        modem_delta = 1'b1; msr_rd = 1'b1; step(); modem_delta = 1'b0; msr_rd = 1'b0;
        chk("R11 event wins", iir, ex(4'b0000));
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        chk("R11 later clear", iir, ex(4'b0001));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_reg();
        t_stack();
        t_rhr_read();
        t_tx_clears();
        t_mask();
        t_out_en();
        t_collide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL all: watchdog got running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule